// File: doc/BRIEF.md
# Dual-domain match timer with synchronized clear

This block holds two 32-bit up-counters behind one small register port that is clocked by the bus clock. The event counter runs on a slow clock (nominally 32768 Hz). When it is running and holds a programmed match value, it raises a one-cycle interrupt pulse, which a rising-edge interrupt input can take. The source counter runs on a fast clock through a 1-to-4 prescaler and serves as a free-running time base.

Every control bit reaches its counter through a two-flop synchronizer. Count values return to the bus domain as Gray code, so a read never returns a torn value. A clear command crosses into the counter domain as a toggle, and a small bus-side state machine keeps a status flag set until the acknowledge toggle has come back. That state machine has two states. CLR_IDLE moves to CLR_WAIT on a clear write, and the request toggle flips on that move. CLR_WAIT returns to CLR_IDLE once the synchronized acknowledge equals the request. Software is expected to program the event counter in this order: stop, clear, set match, wait for the pending flag to fall, then start.

Top module: `dual_match_timer`

## Requirements
- R1: After reset every register reads 0, evt_irq is low, both pending flags are clear and the source divider code is 0 (divide by 1).
- R2: Register offsets (byte addresses on `addr`):

  | Offset | Register | Access | Fields |
  |---|---|---|---|
  | 0x00 | Event match | read/write | match value |
  | 0x04 | Event count | read-only | current count |
  | 0x08 | Event control | read/write | bit 0 run, bit 1 auto-zero |
  | 0x0C | Event clear | write-only | data ignored |
  | 0x24 | Source count | read-only | current count |
  | 0x28 | Source control | read/write | bit 0 run |
  | 0x2C | Source clear | write-only | data ignored |
  | 0x30 | Source divider | read/write | code in bits 1:0 |
  | 0x40 | Status | read-only | bit 10 event clear pending, bit 11 source clear pending |

  Any other address reads 0.
- R3: On a slow edge at which the event counter is running and holds the match value, evt_irq rises and stays high for exactly that slow cycle. At any other time it is low.
- R4: A run bit written on the bus is first obeyed at the third edge of the counter's own clock after the write, because the first two edges fill the synchronizer. While a counter is stopped its count holds.
- R5: When the running event counter steps from the match value, it steps to 0 if auto-zero is set and to match+1 otherwise.
- R6: A write to the event clear register sets status bit 10 in the next bus cycle. The event count becomes 0 at the third slow edge after the write, and bit 10 falls within four bus cycles after that edge.
- R7: A clear write made while the same counter's pending flag is set has no effect.
- R8: With divider code n (0 to 3), the running source counter advances once every n+1 fast edges. A new code is synchronized in the same way as the run bit.
- R9: A write to the source clear register sets status bit 11. At the third fast edge after the write, the source count and its prescaler phase return to 0, and bit 11 then falls.
- R10: A count read returns exactly the value the counter took at its last edge, provided at least four bus cycles have passed since that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register port clock |
| slow_clk | input | 1 | Event counter clock |
| fast_clk | input | 1 | Source counter clock before the prescaler |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| wr_en | input | 1 | Write strobe, sampled on bus_clk |
| addr | input | 8 | Register byte offset |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for `addr`, combinational |
| evt_irq | output | 1 | Event match pulse, one slow cycle |

## Verification
On every clock the assertions check four things: a pulse appears only after an edge that held the match value, a stopped event count stays put, the source count moves by at most one step per fast edge, and the pending flag rises only on a clear write and ignores repeated clear writes. Only the bench scenarios can show the cross-domain latencies. These include the third-edge start and the third-edge clear, the rate set by each divider code, the choice between auto-zero and continuing past the match value, and the fact that bus reads of counts are exact. The bench's reference model advances once per counter edge and compares the interrupt, the count and the status on each of those edges.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
    localparam int ADDR_W = 8;
    localparam int DIV_W  = 2;

    localparam logic [ADDR_W-1:0] OFS_EVT_MATCH = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_EVT_COUNT = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_EVT_CTRL  = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_EVT_CLR   = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_SRC_COUNT = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_SRC_CTRL  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_SRC_CLR   = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_SRC_DIV   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_STATUS    = 8'h40;

    localparam int PEND_EVT_BIT = 10;
    localparam int PEND_SRC_BIT = 11;

    localparam int N_CTR = 2;   // index 0: event counter, 1: source counter

    typedef enum logic {
        CLR_IDLE = 1'b0,
        CLR_WAIT = 1'b1
    } clr_state_e;
endpackage

// File: rtl/sync_bits.sv
module sync_bits #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/clr_handshake.sv
module clr_handshake
    import dmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  logic ack_tgl,
    output logic req_tgl,
    output logic pending
);
    clr_state_e st, st_nxt;
    logic       tgl_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= CLR_IDLE;
            req_tgl <= 1'b0;
        end else begin
            st      <= st_nxt;
            req_tgl <= tgl_nxt;
        end
    end

    // transitions
    always_comb begin
        st_nxt  = st;
        tgl_nxt = req_tgl;
        unique case (st)
            CLR_IDLE: if (go) begin
                st_nxt  = CLR_WAIT;
                tgl_nxt = ~req_tgl;
            end
            CLR_WAIT: if (ack_tgl == req_tgl) st_nxt = CLR_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending = (st == CLR_WAIT);
    end
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_b,
    input  logic         auto_b,
    input  logic [W-1:0] match,
    input  logic         req_tgl,
    output logic         irq,
    output logic [W-1:0] cnt,
    output logic [W-1:0] gray,
    output logic         ack_tgl,
    output logic         run,
    output logic         clr_pulse
);
    logic         auto_s;
    logic         req_s;
    logic [W-1:0] cnt_n;
    logic         irq_n;

    sync_bits #(.W(2), .STAGES(2)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({auto_b, run_b}), .q({auto_s, run})
    );
    sync_bits #(.W(1), .STAGES(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
    );

    assign clr_pulse = req_s ^ ack_tgl;

    always_comb begin
        cnt_n = cnt;
        irq_n = 1'b0;
        if (clr_pulse) begin
            cnt_n = '0;
        end else if (run) begin
            irq_n = (cnt == match);
            cnt_n = (irq_n && auto_s) ? '0 : cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            gray    <= '0;
            irq     <= 1'b0;
            ack_tgl <= 1'b0;
        end else begin
            cnt     <= cnt_n;
            gray    <= cnt_n ^ (cnt_n >> 1);
            irq     <= irq_n;
            ack_tgl <= req_s;
        end
    end
endmodule

// File: rtl/src_counter.sv
module src_counter
    import dmt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_b,
    input  logic [DIV_W-1:0] div_b,
    input  logic             req_tgl,
    output logic [W-1:0]     cnt,
    output logic [W-1:0]     gray,
    output logic             ack_tgl,
    output logic             clr_pulse
);
    logic             run;
    logic [DIV_W-1:0] div_s;
    logic [DIV_W-1:0] pre, pre_n;
    logic             req_s;
    logic [W-1:0]     cnt_n;

    sync_bits #(.W(DIV_W + 1), .STAGES(2)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d({div_b, run_b}), .q({div_s, run})
    );
    sync_bits #(.W(1), .STAGES(2)) u_req_sync (
        .clk(clk), .rst_n(rst_n), .d(req_tgl), .q(req_s)
    );

    assign clr_pulse = req_s ^ ack_tgl;

    always_comb begin
        cnt_n = cnt;
        pre_n = pre;
        if (clr_pulse) begin
            cnt_n = '0;
            pre_n = '0;
        end else if (!run) begin
            pre_n = '0;
        end else if (pre == div_s) begin
            pre_n = '0;
            cnt_n = cnt + 1'b1;
        end else begin
            pre_n = pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt     <= '0;
            gray    <= '0;
            pre     <= '0;
            ack_tgl <= 1'b0;
        end else begin
            cnt     <= cnt_n;
            gray    <= cnt_n ^ (cnt_n >> 1);
            pre     <= pre_n;
            ack_tgl <= req_s;
        end
    end
endmodule

// File: rtl/dual_match_timer.sv
module dual_match_timer
    import dmt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              bus_clk,
    input  logic              slow_clk,
    input  logic              fast_clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    output logic              evt_irq
);
    logic [CNT_W-1:0] evt_match;
    logic             evt_run_b, evt_auto_b, src_run_b;
    logic [DIV_W-1:0] src_div_b;

    logic             clr_go  [N_CTR];
    logic             req_tgl [N_CTR];
    logic             ack_tgl [N_CTR];
    logic             ack_s   [N_CTR];
    logic             pend    [N_CTR];
    logic [CNT_W-1:0] gray_c  [N_CTR];
    logic [CNT_W-1:0] gray_s  [N_CTR];
    logic [CNT_W-1:0] cnt_rd  [N_CTR];

    logic [CNT_W-1:0] evt_cnt, src_cnt;
    logic             evt_run, evt_clr_pulse, src_clr_pulse;

    // register writes
    always_ff @(posedge bus_clk or negedge rst_n) begin
        if (!rst_n) begin
            evt_match  <= '0;
            evt_run_b  <= 1'b0;
            evt_auto_b <= 1'b0;
            src_run_b  <= 1'b0;
            src_div_b  <= '0;
        end else if (wr_en) begin
            case (addr)
                OFS_EVT_MATCH: evt_match <= wdata;
                OFS_EVT_CTRL:  {evt_auto_b, evt_run_b} <= wdata[1:0];
                OFS_SRC_CTRL:  src_run_b <= wdata[0];
                OFS_SRC_DIV:   src_div_b <= wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    assign clr_go[0] = wr_en && (addr == OFS_EVT_CLR);
    assign clr_go[1] = wr_en && (addr == OFS_SRC_CLR);

    // per-counter clear handshake and count snapshot path
    for (genvar k = 0; k < N_CTR; k++) begin : g_path
        sync_bits #(.W(1), .STAGES(2)) u_ack_sync (
            .clk(bus_clk), .rst_n(rst_n), .d(ack_tgl[k]), .q(ack_s[k])
        );
        clr_handshake u_clr (
            .clk(bus_clk), .rst_n(rst_n), .go(clr_go[k]),
            .ack_tgl(ack_s[k]), .req_tgl(req_tgl[k]), .pending(pend[k])
        );
        sync_bits #(.W(CNT_W), .STAGES(2)) u_gray_sync (
            .clk(bus_clk), .rst_n(rst_n), .d(gray_c[k]), .q(gray_s[k])
        );
    end

    always_comb begin
        for (int k = 0; k < N_CTR; k++) begin
            cnt_rd[k][CNT_W-1] = gray_s[k][CNT_W-1];
            for (int i = CNT_W - 2; i >= 0; i--)
                cnt_rd[k][i] = cnt_rd[k][i+1] ^ gray_s[k][i];
        end
    end

    evt_counter #(.W(CNT_W)) u_evt (
        .clk(slow_clk), .rst_n(rst_n), .run_b(evt_run_b), .auto_b(evt_auto_b),
        .match(evt_match), .req_tgl(req_tgl[0]), .irq(evt_irq), .cnt(evt_cnt),
        .gray(gray_c[0]), .ack_tgl(ack_tgl[0]), .run(evt_run),
        .clr_pulse(evt_clr_pulse)
    );

    src_counter #(.W(CNT_W)) u_src (
        .clk(fast_clk), .rst_n(rst_n), .run_b(src_run_b), .div_b(src_div_b),
        .req_tgl(req_tgl[1]), .cnt(src_cnt), .gray(gray_c[1]),
        .ack_tgl(ack_tgl[1]), .clr_pulse(src_clr_pulse)
    );

    // register reads
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_EVT_MATCH: rdata = evt_match;
            OFS_EVT_COUNT: rdata = cnt_rd[0];
            OFS_EVT_CTRL:  rdata[1:0] = {evt_auto_b, evt_run_b};
            OFS_SRC_COUNT: rdata = cnt_rd[1];
            OFS_SRC_CTRL:  rdata[0] = src_run_b;
            OFS_SRC_DIV:   rdata[DIV_W-1:0] = src_div_b;
            OFS_STATUS: begin
                rdata[PEND_EVT_BIT] = pend[0];
                rdata[PEND_SRC_BIT] = pend[1];
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/dmt_checker.sv
module dmt_checker
    import dmt_pkg::*;
#(
    parameter int W = 32
) (
    input logic              bus_clk,
    input logic              slow_clk,
    input logic              fast_clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic              evt_irq,
    input logic              evt_pend,
    input logic              evt_req,
    input logic [W-1:0]      evt_cnt,
    input logic [W-1:0]      evt_match,
    input logic              evt_run,
    input logic              evt_clr_pulse,
    input logic [W-1:0]      src_cnt,
    input logic              src_clr_pulse
);
    // R3: a pulse follows only an edge that held the match value
    a_r3_irq_at_match: assert property (@(posedge slow_clk) disable iff (!rst_n)
        evt_irq |-> ($past(evt_cnt) == $past(evt_match)));

    // R4: a stopped event counter keeps its value
    a_r4_freeze: assert property (@(posedge slow_clk) disable iff (!rst_n)
        (!evt_run && !evt_clr_pulse) |=> $stable(evt_cnt));

    // R8: the source count moves by at most one per fast edge
    a_r8_single_step: assert property (@(posedge fast_clk) disable iff (!rst_n)
        !src_clr_pulse |=> (src_cnt == $past(src_cnt)) || (src_cnt == $past(src_cnt) + 1'b1));

    // R6: the pending flag rises only after a clear write
    a_r6_pend_from_write: assert property (@(posedge bus_clk) disable iff (!rst_n)
        $rose(evt_pend) |-> $past(wr_en && (addr == OFS_EVT_CLR)));

    // R7: a clear write while pending leaves the request untouched
    a_r7_ignore_repeat: assert property (@(posedge bus_clk) disable iff (!rst_n)
        (evt_pend && wr_en && (addr == OFS_EVT_CLR)) |=> $stable(evt_req));
endmodule

bind dual_match_timer dmt_checker #(.W(CNT_W)) u_chk (
    .bus_clk(bus_clk), .slow_clk(slow_clk), .fast_clk(fast_clk), .rst_n(rst_n),
    .wr_en(wr_en), .addr(addr), .evt_irq(evt_irq), .evt_pend(pend[0]),
    .evt_req(req_tgl[0]), .evt_cnt(evt_cnt), .evt_match(evt_match),
    .evt_run(evt_run), .evt_clr_pulse(evt_clr_pulse), .src_cnt(src_cnt),
    .src_clr_pulse(src_clr_pulse)
);

// File: tb/sim_dual_match_timer.sv
module sim_dual_match_timer;
    import dmt_pkg::*;
    localparam int W = 32;

    logic         bus_clk = 1'b0;
    logic         slow_clk = 1'b0;
    logic         fast_clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [7:0]   addr = '0;
    logic [W-1:0] wdata = '0;
    logic [W-1:0] rdata;
    logic         evt_irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 bus_clk = ~bus_clk;   // 50 MHz

    dual_match_timer #(.CNT_W(W)) u0 (
        .bus_clk(bus_clk), .slow_clk(slow_clk), .fast_clk(fast_clk), .rst_n(rst_n),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .evt_irq(evt_irq)
    );

    // reference model: event side
    logic [W-1:0] m_cnt = '0, m_match = '0;
    logic m_en = 0, m_com = 0, m_irq = 0, m_req = 0, m_ep = 0;
    logic e1 = 0, e2 = 0, k1 = 0, k2 = 0, c1 = 0, c2 = 0, c3 = 0;
    // reference model: source side
    logic [W-1:0] f_cnt = '0;
    int   f_pre = 0;
    logic f_en = 0, f_req = 0, f_ep = 0;
    logic [1:0] f_div = 0, fd1 = 0, fd2 = 0;
    logic fe1 = 0, fe2 = 0, fc1 = 0, fc2 = 0, fc3 = 0;

    task automatic check(input string r, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
        @(negedge bus_clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge bus_clk);
        wr_en = 1'b0;
        case (a)
            OFS_EVT_MATCH: m_match = d;
            OFS_EVT_CTRL:  begin m_en = d[0]; m_com = d[1]; end
            OFS_EVT_CLR:   if (!m_ep) begin m_ep = 1'b1; m_req = ~m_req; end
            OFS_SRC_CTRL:  f_en = d[0];
            OFS_SRC_DIV:   f_div = d[1:0];
            OFS_SRC_CLR:   if (!f_ep) begin f_ep = 1'b1; f_req = ~f_req; end
            default: ;
        endcase
    endtask

    task automatic rd(input logic [7:0] a, output logic [W-1:0] v);
        @(negedge bus_clk);
        addr = a;
        #2 v = rdata;
    endtask

    task automatic evt_tick(input string r);
        logic [W-1:0] v;
        if (c2 != c3) begin
            m_cnt = '0; m_irq = 1'b0;
        end else if (e2) begin
            m_irq = (m_cnt == m_match);
            m_cnt = (m_irq && k2) ? '0 : m_cnt + 1;
        end else begin
            m_irq = 1'b0;
        end
        c3 = c2; c2 = c1; c1 = m_req;
        e2 = e1; e1 = m_en; k2 = k1; k1 = m_com;
        m_ep = (c3 != m_req);
        @(negedge bus_clk) slow_clk = 1'b1;
        repeat (5) @(negedge bus_clk);
        slow_clk = 1'b0;
        check({r, " irq"}, W'(evt_irq), W'(m_irq));
        rd(OFS_EVT_COUNT, v);
        check({r, " R10 event count"}, v, m_cnt);
        rd(OFS_STATUS, v);
        check({r, " R6 status bit10"}, W'(v[PEND_EVT_BIT]), W'(m_ep));
    endtask

    task automatic fast_tick(input string r);
        logic [W-1:0] v;
        if (fc2 != fc3) begin
            f_cnt = '0; f_pre = 0;
        end else if (!fe2) begin
            f_pre = 0;
        end else if (f_pre == int'(fd2)) begin
            f_pre = 0; f_cnt = f_cnt + 1;
        end else begin
            f_pre = f_pre + 1;
        end
        fc3 = fc2; fc2 = fc1; fc1 = f_req;
        fe2 = fe1; fe1 = f_en; fd2 = fd1; fd1 = f_div;
        f_ep = (fc3 != f_req);
        @(negedge bus_clk) fast_clk = 1'b1;
        repeat (5) @(negedge bus_clk);
        fast_clk = 1'b0;
        rd(OFS_SRC_COUNT, v);
        check({r, " R10 source count"}, v, f_cnt);
        rd(OFS_STATUS, v);
        check({r, " R9 status bit11"}, W'(v[PEND_SRC_BIT]), W'(f_ep));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge bus_clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W-1:0] v, v2;
        repeat (3) @(negedge bus_clk);
        rst_n = 1'b1;
        @(negedge bus_clk);

        // R1: reset state
        rd(OFS_EVT_MATCH, v); check("R1 match", v, '0);
        rd(OFS_EVT_COUNT, v); check("R1 event count", v, '0);
        rd(OFS_EVT_CTRL, v);  check("R1 event ctrl", v, '0);
        rd(OFS_SRC_COUNT, v); check("R1 source count", v, '0);
        rd(OFS_SRC_DIV, v);   check("R1 divider", v, '0);
        rd(OFS_STATUS, v);    check("R1 status", v, '0);
        check("R1 irq", W'(evt_irq), '0);

        // R2: register map read-back
        wr(OFS_EVT_MATCH, 32'h1234_5678);
        rd(OFS_EVT_MATCH, v); check("R2 match rw", v, 32'h1234_5678);
        wr(OFS_EVT_CTRL, 32'h2);
        rd(OFS_EVT_CTRL, v);  check("R2 ctrl bit1", v, 32'h2);
        wr(OFS_SRC_DIV, 32'h3);
        rd(OFS_SRC_DIV, v);   check("R2 divider rw", v, 32'h3);
        rd(8'h14, v);         check("R2 unmapped", v, '0);
        wr(OFS_SRC_DIV, 32'h0);
        wr(OFS_EVT_CTRL, 32'h0);

        // R6 then R3/R5 with auto-zero: programming sequence
        wr(OFS_EVT_CLR, 32'hFFFF_FFFF);
        rd(OFS_STATUS, v); check("R6 pending set", W'(v[PEND_EVT_BIT]), W'(1));
        wr(OFS_EVT_MATCH, 32'd5);
        repeat (3) evt_tick("R6 clear");
        wr(OFS_EVT_CTRL, 32'h3);
        repeat (20) evt_tick("R3 R5 auto-zero");

        // R5 without auto-zero, then R4 freeze
        wr(OFS_EVT_CTRL, 32'h1);
        repeat (10) evt_tick("R5 continue");
        wr(OFS_EVT_CTRL, 32'h0);
        repeat (6) evt_tick("R4 freeze");

        // R6 clear while running, R7 repeated clear ignored
        wr(OFS_EVT_MATCH, 32'd40);
        wr(OFS_EVT_CTRL, 32'h1);
        repeat (5) evt_tick("R4 restart");
        wr(OFS_EVT_CLR, 32'h0);
        wr(OFS_EVT_CLR, 32'h0);
        repeat (8) evt_tick("R7 ignored");

        // R8: each divider code
        for (int d = 0; d < 4; d++) begin
            wr(OFS_SRC_CTRL, 32'h0);
            wr(OFS_SRC_CLR, 32'h0);
            repeat (3) fast_tick("R9 clear");
            wr(OFS_SRC_DIV, W'(d));
            wr(OFS_SRC_CTRL, 32'h1);
            repeat (14) fast_tick("R8 divide");
        end

        // R9: clear while running
        wr(OFS_SRC_CLR, 32'h0);
        repeat (6) fast_tick("R9 running clear");

        // R10: settled reads are repeatable
        rd(OFS_SRC_COUNT, v);
        rd(OFS_SRC_COUNT, v2);
        check("R10 stable read", v2, v);

        finish_run();
    end
endmodule